// File: doc/BRIEF.md
# USB Core Interrupt Aggregator with End-of-Interrupt Gating

This block gathers single-cycle interrupt events from a USB OTG controller core into one 32-bit source register. The register has three fields: transmit-endpoint events, receive-endpoint events, and core bus events. The core field also carries a bit that marks any change on the VBUS-drive signal. A per-bit enable register selects which source bits may reach the CPU. The block drives one level-sensitive interrupt line.

Once the line has fired it is gated. It falls when the enabled pending bits are cleared, and it cannot rise again until software writes the end-of-interrupt register. Source and enable bits are never written directly. Software changes them only through separate write-one-to-set and write-one-to-clear addresses. Through the set address, software can inject any event exactly as hardware would.

Top module: `usb_irq_agg`

## Requirements
- R1: The revision register at offset 0x00 reads the fixed nonzero parameter value (default 32'h4F54_0102). The status register at 0x08 reads the current level of the VBUS-drive input in bit 0 and zero in all other bits.
- R2: A hardware event pulse sets its source bit on the next clock. The source bits are laid out as follows: transmit events in bits [4:0], receive events in bits [12:9], and core events in bits [23:16]. Bit 24 is set by either edge of the VBUS-drive input. The raw source reads at 0x20.
- R3: Writing to the source-set address 0x24 sets every source bit that is one in the write data.
- R4: Writing to the source-clear address 0x28 clears every source bit that is one in the write data. Bits written as zero keep their value.
- R5: The mask-set address 0x30 sets enable bits and the mask-clear address 0x34 clears them. The enable register reads at 0x2C. Writes to 0x2C, 0x20 and 0x38 change nothing.
- R6: The masked view at 0x38 reads the raw source ANDed with the enable register.
- R7: Bits outside the three fields always read zero in the source, enable and masked registers. Writes to those bits are ignored.
- R8: If a hardware event and a source-clear of the same bit occur in the same cycle, the bit ends up set.
- R9: When the gate is armed and an enabled source bit is pending, the interrupt line rises one clock later. After it has fired, the line falls one clock after no enabled bit remains pending. It stays low, even when new events arrive, until an end-of-interrupt write.
- R10: A write of any value to 0x3C forces the line low on the next clock and re-arms the gate. If an enabled bit is still pending, the line rises on the clock after that. If none is pending, the line stays low.
- R11: Writing 1 in bit 0 of the control register at 0x04 clears the source and enable registers and re-arms the gate. A control write with bit 0 at zero has no effect, and the control register reads zero.
- R12: Read data appears one clock after the read strobe and holds until the next read. After reset the source and enable registers are zero, the gate is armed and the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one clock after the read strobe |
| tx_evt_i | input | 5 | Transmit-endpoint event pulses |
| rx_evt_i | input | 4 | Receive-endpoint event pulses |
| core_evt_i | input | 8 | Core bus event pulses |
| vbus_drv_i | input | 1 | VBUS-drive level from the core |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
The bound checker checks the following on every cycle:
- Bits outside the fields stay zero.
- Set and clear writes take effect.
- A hardware event beats a clear of the same bit.
- An end-of-interrupt write drops the line.
- A fired, disarmed gate never raises the line.
- The line only rises when an enabled bit was pending.
- Read data only changes after a read strobe.

Some behaviour needs the bench's scenarios to show it:
- The exact field placement of each event input, swept bit by bit.
- The two-clock re-assert after an end-of-interrupt write.
- The suppression of new events while disarmed.
- The effect of soft reset on all state.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] A_REV  = 8'h00;
  localparam logic [AW-1:0] A_CTRL = 8'h04;
  localparam logic [AW-1:0] A_STAT = 8'h08;
  localparam logic [AW-1:0] A_SRC  = 8'h20;
  localparam logic [AW-1:0] A_SSET = 8'h24;
  localparam logic [AW-1:0] A_SCLR = 8'h28;
  localparam logic [AW-1:0] A_MASK = 8'h2C;
  localparam logic [AW-1:0] A_MSET = 8'h30;
  localparam logic [AW-1:0] A_MCLR = 8'h34;
  localparam logic [AW-1:0] A_MSRC = 8'h38;
  localparam logic [AW-1:0] A_EOI  = 8'h3C;

  // ones over [0,ntx), [rxl,rxl+nrx), [crl,crl+ncr]; the extra core bit is VBUS change
  function automatic logic [DW-1:0] field_mask(int ntx, int rxl, int nrx, int crl, int ncr);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < ntx) m[i] = 1'b1;
      if (i >= rxl && i < rxl + nrx) m[i] = 1'b1;
      if (i >= crl && i <= crl + ncr) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/usb_irq_w1sc.sv
module usb_irq_w1sc #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wipe_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] hw_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_n;

  always_comb begin
    // hardware and software set are applied after the clear so they win
    q_n = ((q_q & ~clr_i) | set_i | hw_i) & KEEP;
    if (wipe_i) q_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_n;
  end

  assign q_o = q_q;
endmodule

// File: rtl/usb_irq_eoi_gate.sv
module usb_irq_eoi_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rearm_i,
  input  logic pend_i,
  output logic irq_o,
  output logic armed_o
);
  logic armed_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (rearm_i) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (armed_q) begin
      if (pend_i) begin
        armed_q <= 1'b0;
        irq_q   <= 1'b1;
      end
    end else begin
      // fired: may only fall until re-armed
      irq_q <= irq_q & pend_i;
    end
  end

  assign irq_o   = irq_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg #(
  parameter int unsigned NUM_TX   = 5,
  parameter int unsigned NUM_RX   = 4,
  parameter int unsigned RX_LSB   = 9,
  parameter int unsigned NUM_CORE = 8,
  parameter int unsigned CORE_LSB = 16,
  parameter logic [31:0] REVISION = 32'h4F54_0102
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic [4:0]  tx_evt_i,
  input  logic [3:0]  rx_evt_i,
  input  logic [7:0]  core_evt_i,
  input  logic        vbus_drv_i,
  output logic        irq_o
);
  import usb_irq_pkg::*;

  localparam int unsigned VBUS_BIT = CORE_LSB + NUM_CORE;
  localparam logic [DW-1:0] FIELD =
    field_mask(int'(NUM_TX), int'(RX_LSB), int'(NUM_RX), int'(CORE_LSB), int'(NUM_CORE));

  logic          vbus_q, vbus_chg;
  logic [DW-1:0] hw_evt, src_q, mask_q, msrc;
  logic [DW-1:0] src_set, src_clr, msk_set, msk_clr;
  logic          soft_rst, eoi_wr, armed;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vbus_q <= 1'b0;
    else         vbus_q <= vbus_drv_i;
  end
  assign vbus_chg = vbus_q ^ vbus_drv_i;

  always_comb begin
    hw_evt = '0;
    hw_evt[NUM_TX-1:0]           = tx_evt_i[NUM_TX-1:0];
    hw_evt[RX_LSB +: NUM_RX]     = rx_evt_i[NUM_RX-1:0];
    hw_evt[CORE_LSB +: NUM_CORE] = core_evt_i[NUM_CORE-1:0];
    hw_evt[VBUS_BIT]             = vbus_chg;
  end

  assign soft_rst = reg_wr_i && (reg_addr_i == A_CTRL) && reg_wdata_i[0];
  assign eoi_wr   = reg_wr_i && (reg_addr_i == A_EOI);
  assign src_set  = (reg_wr_i && reg_addr_i == A_SSET) ? reg_wdata_i : '0;
  assign src_clr  = (reg_wr_i && reg_addr_i == A_SCLR) ? reg_wdata_i : '0;
  assign msk_set  = (reg_wr_i && reg_addr_i == A_MSET) ? reg_wdata_i : '0;
  assign msk_clr  = (reg_wr_i && reg_addr_i == A_MCLR) ? reg_wdata_i : '0;

  usb_irq_w1sc #(.W(DW), .KEEP(FIELD)) u_src (
    .clk_i, .rst_ni, .wipe_i(soft_rst),
    .set_i(src_set), .clr_i(src_clr), .hw_i(hw_evt), .q_o(src_q)
  );

  usb_irq_w1sc #(.W(DW), .KEEP(FIELD)) u_mask (
    .clk_i, .rst_ni, .wipe_i(soft_rst),
    .set_i(msk_set), .clr_i(msk_clr), .hw_i('0), .q_o(mask_q)
  );

  assign msrc = src_q & mask_q;

  usb_irq_eoi_gate u_gate (
    .clk_i, .rst_ni, .rearm_i(eoi_wr || soft_rst),
    .pend_i(|msrc), .irq_o(irq_o), .armed_o(armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (reg_rd_i) begin
      unique case (reg_addr_i)
        A_REV:   rdata_q <= REVISION;
        A_STAT:  rdata_q <= {{(DW-1){1'b0}}, vbus_drv_i};
        A_SRC:   rdata_q <= src_q;
        A_MASK:  rdata_q <= mask_q;
        A_MSRC:  rdata_q <= msrc;
        default: rdata_q <= '0;
      endcase
    end
  end
  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/usb_irq_agg_chk.sv
module usb_irq_agg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic        reg_rd_i,
  input logic [7:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic [31:0] hw_evt_i,
  input logic [31:0] src_i,
  input logic [31:0] mask_i,
  input logic [31:0] field_i,
  input logic        armed_i,
  input logic        irq_o
);
  logic wr_sset, wr_sclr, wr_ctrl1, wr_eoi;
  assign wr_sset  = reg_wr_i && reg_addr_i == 8'h24;
  assign wr_sclr  = reg_wr_i && reg_addr_i == 8'h28;
  assign wr_ctrl1 = reg_wr_i && reg_addr_i == 8'h04 && reg_wdata_i[0];
  assign wr_eoi   = reg_wr_i && reg_addr_i == 8'h3C;

  assert_outside_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i | mask_i) & ~field_i) == 32'h0);

  assert_set_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sset |=> ((src_i & $past(reg_wdata_i & field_i)) == $past(reg_wdata_i & field_i)));

  assert_clear_takes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sclr && ((reg_wdata_i & hw_evt_i) == 32'h0)) |=> ((src_i & $past(reg_wdata_i)) == 32'h0));

  assert_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|hw_evt_i) && !wr_ctrl1) |=> ((src_i & $past(hw_evt_i)) == $past(hw_evt_i)));

  assert_eoi_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_eoi |=> !irq_o);

  assert_no_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !irq_o) |=> !irq_o);

  assert_rise_needs_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(src_i & mask_i)));

  assert_soft_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl1 |=> (src_i == 32'h0 && mask_i == 32'h0 && !irq_o));

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

bind usb_irq_agg usb_irq_agg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .hw_evt_i(hw_evt), .src_i(src_q), .mask_i(mask_q), .field_i(FIELD),
  .armed_i(armed), .irq_o(irq_o)
);

// File: tb/usb_irq_agg_tb.sv
module usb_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0]  tx = '0;
  logic [3:0]  rx = '0;
  logic [7:0]  core = '0;
  logic        vbus = 1'b0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [31:0] FLD = 32'h1F | (32'hF << 9) | (32'h1FF << 16);

  always #10 clk = ~clk;

  usb_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_evt_i(tx), .rx_evt_i(rx),
    .core_evt_i(core), .vbus_drv_i(vbus), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [4:0] t, input logic [3:0] r, input logic [7:0] c);
    @(negedge clk); tx = t; rx = r; core = c;
    @(negedge clk); tx = '0; rx = '0; core = '0;
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    report();
  end

  initial begin
    logic [31:0] d, hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset irq", {31'b0, irq}, 32'h0);
    rd_reg(8'h20, d); chk("R12 reset src", d, 32'h0);
    rd_reg(8'h2C, d); chk("R12 reset mask", d, 32'h0);
    rd_reg(8'h00, d); chk("R1 revision", d, 32'h4F54_0102);
    rd_reg(8'h08, d); chk("R1 status low", d, 32'h0);
    rd_reg(8'h04, d); chk("R11 ctrl reads zero", d, 32'h0);
    hold = d;
    repeat (3) @(negedge clk);
    chk("R12 rdata holds", rdata, hold);

    // R3 R4 R7 per-bit software set/clear sweep
    for (int i = 0; i < 32; i++) begin
      wr_reg(8'h24, 32'h1 << i);
      rd_reg(8'h20, d); chk("R3 R7 set bit", d, (32'h1 << i) & FLD);
      wr_reg(8'h28, 32'h1 << i);
      rd_reg(8'h20, d); chk("R4 clear bit", d, 32'h0);
    end
    wr_reg(8'h24, 32'hFFFF_FFFF);
    rd_reg(8'h20, d); chk("R7 set all", d, FLD);
    wr_reg(8'h28, 32'h0);
    rd_reg(8'h20, d); chk("R4 zero clear no effect", d, FLD);
    wr_reg(8'h20, 32'h0);
    rd_reg(8'h20, d); chk("R5 raw src write ignored", d, FLD);
    wr_reg(8'h28, 32'h0001_0204);
    rd_reg(8'h20, d); chk("R4 partial clear", d, FLD & ~32'h0001_0204);
    wr_reg(8'h28, 32'hFFFF_FFFF);

    // R2 hardware event sweep
    for (int j = 0; j < 5; j++) begin
      pulse(5'(1 << j), '0, '0);
      rd_reg(8'h20, d); chk("R2 tx event", d, 32'h1 << j);
      wr_reg(8'h28, 32'hFFFF_FFFF);
    end
    for (int j = 0; j < 4; j++) begin
      pulse('0, 4'(1 << j), '0);
      rd_reg(8'h20, d); chk("R2 rx event", d, 32'h1 << (9 + j));
      wr_reg(8'h28, 32'hFFFF_FFFF);
    end
    for (int j = 0; j < 8; j++) begin
      pulse('0, '0, 8'(1 << j));
      rd_reg(8'h20, d); chk("R2 core event", d, 32'h1 << (16 + j));
      wr_reg(8'h28, 32'hFFFF_FFFF);
    end
    @(negedge clk); vbus = 1'b1;
    rd_reg(8'h20, d); chk("R2 vbus rise", d, 32'h0100_0000);
    rd_reg(8'h08, d); chk("R1 status high", d, 32'h1);
    wr_reg(8'h28, 32'hFFFF_FFFF);
    rd_reg(8'h20, d); chk("R2 vbus steady no event", d, 32'h0);
    @(negedge clk); vbus = 1'b0;
    rd_reg(8'h20, d); chk("R2 vbus fall", d, 32'h0100_0000);
    wr_reg(8'h28, 32'hFFFF_FFFF);

    // R5 R7 mask sweep
    for (int i = 0; i < 32; i++) begin
      wr_reg(8'h30, 32'h1 << i);
      rd_reg(8'h2C, d); chk("R5 mask set", d, FLD & ((i == 31) ? 32'hFFFF_FFFF : ((32'h1 << (i + 1)) - 1)));
    end
    wr_reg(8'h2C, 32'h0);
    rd_reg(8'h2C, d); chk("R5 mask write ignored", d, FLD);
    wr_reg(8'h38, 32'h0);
    rd_reg(8'h2C, d); chk("R5 masked write ignored", d, FLD);
    wr_reg(8'h34, 32'h00F0_0E0A);
    rd_reg(8'h2C, d); chk("R5 mask clear", d, FLD & ~32'h00F0_0E0A);
    wr_reg(8'h24, 32'h00AA_1A15);
    rd_reg(8'h38, d); chk("R6 masked view", d, 32'h00AA_1A15 & FLD & ~32'h00F0_0E0A);

    // R11 soft reset
    wr_reg(8'h04, 32'hFFFF_FFFE);
    rd_reg(8'h20, d); chk("R11 ctrl bit0 zero no effect", d, 32'h00AA_1A15 & FLD);
    wr_reg(8'h04, 32'h1);
    rd_reg(8'h20, d); chk("R11 soft reset src", d, 32'h0);
    rd_reg(8'h2C, d); chk("R11 soft reset mask", d, 32'h0);
    chk("R11 soft reset irq", {31'b0, irq}, 32'h0);

    // R8 event beats clear
    wr_reg(8'h24, 32'h6);
    @(negedge clk); wr = 1'b1; addr = 8'h28; wdata = 32'h6; tx = 5'h4;
    @(negedge clk); wr = 1'b0; tx = '0;
    rd_reg(8'h20, d); chk("R8 event wins over clear", d, 32'h4);
    wr_reg(8'h28, 32'hFFFF_FFFF);

    // R9 R10 interrupt gating
    wr_reg(8'h30, 32'h1);
    pulse(5'h2, '0, '0);
    repeat (2) @(negedge clk);
    chk("R9 unmasked event no irq", {31'b0, irq}, 32'h0);
    wr_reg(8'h28, 32'hFFFF_FFFF);
    pulse(5'h1, '0, '0);
    chk("R9 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq rises one clock after", {31'b0, irq}, 32'h1);
    wr_reg(8'h28, 32'h1);
    chk("R9 irq still high at clear edge", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq falls after service", {31'b0, irq}, 32'h0);
    pulse(5'h1, '0, '0);
    repeat (4) @(negedge clk);
    chk("R9 no reassert without eoi", {31'b0, irq}, 32'h0);
    wr_reg(8'h3C, 32'h0);
    chk("R10 eoi cycle low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 reassert after eoi", {31'b0, irq}, 32'h1);
    wr_reg(8'h3C, 32'h1234_5678);
    chk("R10 eoi forces low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 pending reasserts", {31'b0, irq}, 32'h1);
    wr_reg(8'h28, 32'h1);
    @(negedge clk);
    wr_reg(8'h3C, 32'h0);
    repeat (3) @(negedge clk);
    chk("R10 eoi no pending stays low", {31'b0, irq}, 32'h0);
    pulse(5'h1, '0, '0);
    @(negedge clk);
    chk("R10 rearmed fires", {31'b0, irq}, 32'h1);
    wr_reg(8'h04, 32'h1);
    chk("R11 soft reset drops irq", {31'b0, irq}, 32'h0);

    report();
  end
endmodule